// File: doc/BRIEF.md
# Vertical Sync Lock Flywheel

This block keeps a line and field count for a video timing chain and brings it into step with an incoming vertical reference. A one-cycle strobe arrives once per line. The reference is either the vertical pulse taken from the separated video sync or an external vertical input. The external input can be treated as active high or active low. A reference pulse counts only once it has stayed active across a minimum number of line strobes.

While the block is hunting, every qualified reference pulse moves the line counter straight to the position it predicts. Each field is then scored as a hit or a miss, according to whether the qualified pulse arrived within one line of that prediction. After a set number of hits in a row, the block enters the locked state. In the locked state the counter runs on its own and reference pulses no longer move it. The block leaves the locked state only after a set number of misses in a row.

The state machine has two states. HUNT moves to LOCKED on the acquire transition, which is the ACQ_FIELDS-th consecutive hit field. LOCKED returns to HUNT on the release transition, which is the LOSE_FIELDS-th consecutive miss field. In HUNT a miss field clears the hit count. In LOCKED a hit field clears the miss count.

Top module: `vsync_flywheel_lock`

## Requirements
- R1: With `src_sel`=0 the reference is `vid_vsync`. With `src_sel`=1 the reference is `ext_vin`. The input that is not selected has no effect on the line counter or on the lock.
- R2: With `ext_pol`=0 the external input is active high and is taken on its rising edge. With `ext_pol`=1 it is active low and is taken on its falling edge.
- R3: A reference pulse qualifies at the MIN_PULSE_LINES-th strobe (default 2) that it is seen active. A pulse that is active for fewer strobes is rejected: it moves no counter and scores no hit.
- R4: The counter `line_cnt` advances by one on each strobe. A field with `field_odd`=0 lasts (N+1)/2 lines and a field with `field_odd`=1 lasts N/2 lines. N is LINES_A when `fmt_sel`=0 and LINES_B when `fmt_sel`=1. When the counter wraps to 0, `vpulse` is high for exactly one cycle and `field_odd` toggles.
- R5: In HUNT, the strobe that qualifies a reference pulse loads `line_cnt` with MIN_PULSE_LINES, whatever value the counter held.
- R6: A qualification is a hit when `line_cnt` is between 0 and MIN_PULSE_LINES inclusive at the qualifying strobe. A field is scored at the strobe where `line_cnt` equals MIN_PULSE_LINES+1.
- R7: `lock` rises after ACQ_FIELDS consecutive hit fields (default 4). A single miss field in HUNT restarts the count.
- R8: In LOCKED, qualified pulses never load the counter; it keeps its own count (flywheel).
- R9: `lock` falls after LOSE_FIELDS consecutive miss fields (default 8). A single hit field in LOCKED restarts the count.
- R10: During reset and just after it, `lock`, `line_cnt`, `field_odd` and `vpulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_strobe | input | 1 | One-cycle pulse per line |
| src_sel | input | 1 | Reference source: 0 video sync, 1 external |
| ext_pol | input | 1 | External polarity: 0 active high, 1 active low |
| vid_vsync | input | 1 | Vertical level from the sync separator, active high |
| ext_vin | input | 1 | External vertical input |
| fmt_sel | input | 1 | Line format: 0 LINES_A, 1 LINES_B |
| lock | output | 1 | High in LOCKED |
| line_cnt | output | CW | Line within the current field |
| field_odd | output | 1 | Field parity |
| vpulse | output | 1 | Internal vertical pulse, one cycle at each wrap |

## Verification
The assertions check on every cycle how the counter and the lock relate to each other:
- The counter holds between strobes.
- `vpulse` only ever appears with the counter at zero, and the parity only changes with it.
- While locked, the counter only steps by one or wraps.
- `lock` changes only on a strobe.

Only the bench scenarios can show the field-level behaviour:
- the exact field lengths in both formats;
- the load in HUNT;
- the rejection of narrow pulses and of the input that is not selected;
- the window edges at both ends;
- the exact field counts for acquire and release.

// File: rtl/vlock_pkg.sv
package vlock_pkg;
    typedef enum logic [0:0] {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/vref_qualifier.sv
module vref_qualifier #(
    parameter int MIN_PULSE_LINES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_strobe,
    input  logic src_sel,
    input  logic ext_pol,
    input  logic vid_vsync,
    input  logic ext_vin,
    output logic qual
);
    localparam int WW = $clog2(MIN_PULSE_LINES + 1);

    logic          ref_r;
    logic [WW-1:0] wcnt;

    // registered reference level, polarity folded in for the external pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_r <= 1'b0;
        end else begin
            ref_r <= src_sel ? (ext_vin ^ ext_pol) : vid_vsync;
        end
    end

    // width counter in lines, saturating at the minimum width
    always_ff @(posedge clk) begin
        if (!rst_n || !ref_r) begin
            wcnt <= '0;
        end else if (h_strobe && wcnt != WW'(MIN_PULSE_LINES)) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    assign qual = h_strobe && ref_r && (wcnt == WW'(MIN_PULSE_LINES - 1));
endmodule

// File: rtl/vline_counter.sv
module vline_counter #(
    parameter int LINES_A     = 525,
    parameter int LINES_B     = 625,
    parameter int RELOAD_LINE = 2,
    parameter int CW          = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_strobe,
    input  logic          fmt_sel,
    input  logic          reload,
    output logic [CW-1:0] line_cnt,
    output logic          field_odd,
    output logic          vpulse
);
    localparam int LAST_A_EVEN = (LINES_A + 1) / 2 - 1;
    localparam int LAST_A_ODD  = LINES_A / 2 - 1;
    localparam int LAST_B_EVEN = (LINES_B + 1) / 2 - 1;
    localparam int LAST_B_ODD  = LINES_B / 2 - 1;

    logic [CW-1:0] field_last;
    logic          wrap;

    always_comb begin
        if (fmt_sel) begin
            field_last = field_odd ? CW'(LAST_B_ODD) : CW'(LAST_B_EVEN);
        end else begin
            field_last = field_odd ? CW'(LAST_A_ODD) : CW'(LAST_A_EVEN);
        end
    end

    assign wrap = h_strobe && !reload && (line_cnt >= field_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt  <= '0;
            field_odd <= 1'b0;
            vpulse    <= 1'b0;
        end else begin
            vpulse <= wrap;
            if (reload) begin
                line_cnt <= CW'(RELOAD_LINE);
            end else if (wrap) begin
                line_cnt  <= '0;
                field_odd <= !field_odd;
            end else if (h_strobe) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vlock_fsm.sv
module vlock_fsm
    import vlock_pkg::*;
#(
    parameter int ACQ_FIELDS  = 4,
    parameter int LOSE_FIELDS = 8,
    parameter int WIN_HI      = 2,
    parameter int CW          = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_strobe,
    input  logic          qual,
    input  logic [CW-1:0] line_cnt,
    output logic          locked,
    output logic          reload
);
    localparam int HW = $clog2(ACQ_FIELDS + 1);
    localparam int MW = $clog2(LOSE_FIELDS + 1);

    lock_state_t   st, st_nx;
    logic [HW-1:0] hit_cnt, hit_nx;
    logic [MW-1:0] miss_cnt, miss_nx;
    logic          win_hit;
    logic          hit_now;
    logic          eval;

    assign hit_now = qual && (line_cnt <= CW'(WIN_HI));
    assign eval    = h_strobe && (line_cnt == CW'(WIN_HI + 1));

    // state register and field counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_HUNT;
            hit_cnt  <= '0;
            miss_cnt <= '0;
            win_hit  <= 1'b0;
        end else begin
            st       <= st_nx;
            hit_cnt  <= hit_nx;
            miss_cnt <= miss_nx;
            if (eval) begin
                win_hit <= 1'b0;
            end else if (hit_now) begin
                win_hit <= 1'b1;
            end
        end
    end

    // transitions: acquire (HUNT->LOCKED), release (LOCKED->HUNT)
    always_comb begin
        st_nx   = st;
        hit_nx  = hit_cnt;
        miss_nx = miss_cnt;
        unique case (st)
            ST_HUNT: begin
                if (eval) begin
                    if (!win_hit) begin
                        hit_nx = '0;
                    end else if (hit_cnt == HW'(ACQ_FIELDS - 1)) begin
                        st_nx   = ST_LOCKED;
                        hit_nx  = '0;
                        miss_nx = '0;
                    end else begin
                        hit_nx = hit_cnt + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (eval) begin
                    if (win_hit) begin
                        miss_nx = '0;
                    end else if (miss_cnt == MW'(LOSE_FIELDS - 1)) begin
                        st_nx   = ST_HUNT;
                        hit_nx  = '0;
                        miss_nx = '0;
                    end else begin
                        miss_nx = miss_cnt + 1'b1;
                    end
                end
            end
            default: st_nx = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        locked = (st == ST_LOCKED);
        reload = qual && (st == ST_HUNT);
    end
endmodule

// File: rtl/vsync_flywheel_lock.sv
module vsync_flywheel_lock #(
    parameter int LINES_A         = 525,
    parameter int LINES_B         = 625,
    parameter int ACQ_FIELDS      = 4,
    parameter int LOSE_FIELDS     = 8,
    parameter int MIN_PULSE_LINES = 2,
    localparam int MAX_FIELD      = ((LINES_A > LINES_B ? LINES_A : LINES_B) + 1) / 2,
    localparam int CW             = $clog2(MAX_FIELD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_strobe,
    input  logic          src_sel,
    input  logic          ext_pol,
    input  logic          vid_vsync,
    input  logic          ext_vin,
    input  logic          fmt_sel,
    output logic          lock,
    output logic [CW-1:0] line_cnt,
    output logic          field_odd,
    output logic          vpulse
);
    logic qual;
    logic reload;

    vref_qualifier #(
        .MIN_PULSE_LINES(MIN_PULSE_LINES)
    ) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_strobe (h_strobe),
        .src_sel  (src_sel),
        .ext_pol  (ext_pol),
        .vid_vsync(vid_vsync),
        .ext_vin  (ext_vin),
        .qual     (qual)
    );

    vline_counter #(
        .LINES_A    (LINES_A),
        .LINES_B    (LINES_B),
        .RELOAD_LINE(MIN_PULSE_LINES),
        .CW         (CW)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_strobe (h_strobe),
        .fmt_sel  (fmt_sel),
        .reload   (reload),
        .line_cnt (line_cnt),
        .field_odd(field_odd),
        .vpulse   (vpulse)
    );

    vlock_fsm #(
        .ACQ_FIELDS (ACQ_FIELDS),
        .LOSE_FIELDS(LOSE_FIELDS),
        .WIN_HI     (MIN_PULSE_LINES),
        .CW         (CW)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_strobe(h_strobe),
        .qual    (qual),
        .line_cnt(line_cnt),
        .locked  (lock),
        .reload  (reload)
    );
endmodule

// File: rtl/vsync_flywheel_lock_chk.sv
module vsync_flywheel_lock_chk #(
    parameter int LINES_A = 525,
    parameter int LINES_B = 625,
    parameter int CW      = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_strobe,
    input logic          lock,
    input logic [CW-1:0] line_cnt,
    input logic          field_odd,
    input logic          vpulse
);
    localparam int MAX_LAST = ((LINES_A > LINES_B ? LINES_A : LINES_B) + 1) / 2 - 1;

    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !h_strobe |=> $stable(line_cnt));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= CW'(MAX_LAST));

    p_vpulse_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vpulse |-> (line_cnt == '0));

    p_parity_with_vpulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vpulse |-> $stable(field_odd));

    p_flywheel_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> (line_cnt == $past(line_cnt) ||
                                   line_cnt == $past(line_cnt) + CW'(1) ||
                                   line_cnt == '0));

    p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(h_strobe));

    p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(h_strobe));
endmodule

bind vsync_flywheel_lock vsync_flywheel_lock_chk #(
    .LINES_A(LINES_A),
    .LINES_B(LINES_B),
    .CW     (CW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_strobe (h_strobe),
    .lock     (lock),
    .line_cnt (line_cnt),
    .field_odd(field_odd),
    .vpulse   (vpulse)
);

// File: tb/vsync_flywheel_lock_tb.sv
module vsync_flywheel_lock_tb_top;
    localparam int TB_A  = 21;
    localparam int TB_B  = 25;
    localparam int TB_CW = $clog2((TB_B + 1) / 2 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_strobe = 1'b0;
    logic src_sel = 1'b0;
    logic ext_pol = 1'b0;
    logic vid_vsync = 1'b0;
    logic ext_vin = 1'b0;
    logic fmt_sel = 1'b0;
    logic lock;
    logic [TB_CW-1:0] line_cnt;
    logic field_odd;
    logic vpulse;

    int n_chk = 0;
    int n_err = 0;
    bit bf_odd = 1'b0;
    bit pulse_vid = 1'b1;
    bit pulse_ext = 1'b0;
    bit ext_idle = 1'b0;
    int probe_val = -1;

    always #10 clk = !clk;

    vsync_flywheel_lock #(
        .LINES_A(TB_A),
        .LINES_B(TB_B)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_strobe (h_strobe),
        .src_sel  (src_sel),
        .ext_pol  (ext_pol),
        .vid_vsync(vid_vsync),
        .ext_vin  (ext_vin),
        .fmt_sel  (fmt_sel),
        .lock     (lock),
        .line_cnt (line_cnt),
        .field_odd(field_odd),
        .vpulse   (vpulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int flen(input bit fmt, input bit odd);
        int total = fmt ? TB_B : TB_A;
        return odd ? total / 2 : (total + 1) / 2;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        h_strobe = 1'b0;
        vid_vsync = 1'b0;
        ext_vin = ext_idle;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bf_odd = 1'b0;
    endtask

    // one bench field; pulse active on lines [off, off+wid) plus last line if lead
    task automatic run_field(input int off, input int wid, input bit lead,
                             input bit sweep, input int probe);
        int len = flen(fmt_sel, bf_odd);
        for (int l = 0; l < len; l++) begin
            bit act = (l >= off && l < off + wid) || (lead && l == len - 1);
            vid_vsync = pulse_vid ? act : 1'b0;
            ext_vin = (pulse_ext && act) ? !ext_idle : ext_idle;
            repeat (2) @(negedge clk);
            h_strobe = 1'b1;
            @(negedge clk);
            h_strobe = 1'b0;
            if (l == probe) probe_val = int'(line_cnt);
            if (sweep) begin
                chk("R4 line_cnt", int'(line_cnt), (l == len - 1) ? 0 : l + 1);
                chk("R4 vpulse", int'(vpulse), (l == len - 1) ? 1 : 0);
                chk("R4 field_odd", int'(field_odd), (l == len - 1) ? int'(!bf_odd) : int'(bf_odd));
            end
        end
        bf_odd = !bf_odd;
    endtask

    task automatic good_fields(input int n);
        for (int i = 0; i < n; i++) run_field(0, 3, 1'b0, 1'b0, -1);
    endtask

    task automatic empty_fields(input int n);
        for (int i = 0; i < n; i++) run_field(99, 0, 1'b0, 1'b0, -1);
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R10 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 lock", int'(lock), 0);
        chk("R10 line_cnt", int'(line_cnt), 0);
        chk("R10 field_odd", int'(field_odd), 0);
        chk("R10 vpulse", int'(vpulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 line_cnt after release", int'(line_cnt), 0);

        // R4 field length sweep, both formats, no reference
        fmt_sel = 1'b0;
        do_reset();
        for (int f = 0; f < 3; f++) run_field(99, 0, 1'b0, 1'b1, -1);
        fmt_sel = 1'b1;
        do_reset();
        for (int f = 0; f < 3; f++) run_field(99, 0, 1'b0, 1'b1, -1);
        fmt_sel = 1'b0;

        // R7 acquisition with an interruption, R1 video source
        do_reset();
        good_fields(3);
        chk("R7 no lock after 3 hits", int'(lock), 0);
        empty_fields(1);
        good_fields(3);
        chk("R7 miss restarted count", int'(lock), 0);
        good_fields(1);
        chk("R7 R1 lock after 4 hits", int'(lock), 1);
        // R9 hysteresis
        empty_fields(7);
        chk("R9 held after 7 misses", int'(lock), 1);
        good_fields(1);
        empty_fields(7);
        chk("R9 hit restarted miss count", int'(lock), 1);
        empty_fields(1);
        chk("R9 released after 8 misses", int'(lock), 0);

        // R5 R3 reload in HUNT with a minimum-width pulse
        do_reset();
        run_field(5, 2, 1'b0, 1'b0, 6);
        chk("R5 R3 reload to 2", probe_val, 2);

        // R3 one-line pulse rejected
        do_reset();
        run_field(5, 1, 1'b0, 1'b0, 6);
        chk("R3 narrow pulse no reload", probe_val, 7);
        for (int i = 0; i < 7; i++) run_field(0, 1, 1'b0, 1'b0, -1);
        chk("R3 narrow pulses never lock", int'(lock), 0);

        // R1 R2 external source, active high
        src_sel = 1'b1; ext_pol = 1'b0; ext_idle = 1'b0;
        pulse_vid = 1'b0; pulse_ext = 1'b1;
        do_reset();
        good_fields(4);
        chk("R1 R2 ext active-high lock", int'(lock), 1);
        // R2 active low
        ext_pol = 1'b1; ext_idle = 1'b1;
        do_reset();
        good_fields(3);
        chk("R2 ext active-low not yet", int'(lock), 0);
        good_fields(1);
        chk("R2 ext active-low lock", int'(lock), 1);
        // R1 unselected video input ignored
        ext_pol = 1'b0; ext_idle = 1'b0;
        pulse_vid = 1'b1; pulse_ext = 1'b0;
        do_reset();
        run_field(5, 3, 1'b0, 1'b0, 6);
        chk("R1 video ignored when ext selected", probe_val, 7);
        // R1 unselected external input ignored
        src_sel = 1'b0; pulse_vid = 1'b0; pulse_ext = 1'b1;
        do_reset();
        run_field(5, 3, 1'b0, 1'b0, 6);
        chk("R1 ext ignored when video selected", probe_val, 7);
        pulse_vid = 1'b1; pulse_ext = 1'b0;

        // R8 flywheel and R6 window edges while locked
        do_reset();
        good_fields(4);
        chk("R7 locked for flywheel test", int'(lock), 1);
        run_field(5, 3, 1'b0, 1'b0, 6);
        chk("R8 no reload when locked", probe_val, 7);
        for (int i = 0; i < 10; i++) run_field(1, 3, 1'b0, 1'b0, -1);
        chk("R6 upper edge counts as hit", int'(lock), 1);
        run_field(99, 0, 1'b1, 1'b0, -1);
        for (int i = 0; i < 10; i++) run_field(0, 1, 1'b1, 1'b0, -1);
        chk("R6 lower edge counts as hit", int'(lock), 1);
        for (int i = 0; i < 7; i++) run_field(2, 3, 1'b0, 1'b0, -1);
        chk("R6 outside window 7 fields", int'(lock), 1);
        run_field(2, 3, 1'b0, 1'b0, -1);
        chk("R6 R9 outside window releases", int'(lock), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule